// File: doc/BRIEF.md
# Clock Divider and Power-Mode Controller

The block takes one input clock and produces the internal clock enables of a small embedded system. A free-running phase bit splits the input clock into an internal clock at half its rate. Core and peripheral enables pulse once per internal cycle. A baud enable for the serial units is the peripheral rate divided by a fixed ratio, which is 2 by default. A prescaled enable for timers and the synchronous serial unit comes from a programmable divisor. The block also drives a clock-output pin that follows the internal clock.

Three power modes gate these enables. Run lets everything through. Idle stops only the core enable, so the peripheral enables and their counters keep going. Powerdown stops the core enable, every peripheral enable and the clock output, and the peripheral counters hold their count. Software writes the prescaler divisor and the requested mode through a single-cycle write port. A wake input, driven by an interrupt or reset source, forces the block back to run. Mode changes are applied only on internal-clock boundaries, so no enable pulse is ever cut short.

Top module: `clkpm_ctrl`

## Requirements
- R1: While `rst_n` is low, every enable is low, `clk_out` is low and `pm_mode` reads 00 (run). The divisor resets to 0 and the requested mode resets to run.
- R2: The internal tick is high on every second input clock, starting at the first edge after reset. In run mode, `core_en` and `periph_en` are high exactly in the tick cycles.
- R3: `baud_en` is high on every BAUD_DIV-th `periph_en` pulse and only together with `periph_en`. With the default BAUD_DIV of 2, that is one pulse every 4 input clocks in run mode.
- R4: With an active divisor N, `pscl_en` is high on every (N+2)-th `periph_en` pulse and only together with `periph_en`.
- R5: Writing the divisor register (`wr_addr`=0, value in `wr_data`) does not change the period in progress. The new value becomes active at the next prescaler terminal count.
- R6: In idle mode (code 01), `core_en` stays low. `periph_en`, `baud_en`, `pscl_en` and `clk_out` keep running.
- R7: In powerdown mode (code 10), `core_en`, `periph_en`, `baud_en`, `pscl_en` and `clk_out` are all low. The baud and prescaler counters hold their values and resume from them after wake.
- R8: A mode write (`wr_addr`=1, code in `wr_data[1:0]`: 00 run, 01 idle, 10 powerdown) is registered as a request. `pm_mode` takes the request at the first tick edge after the write is registered, and changes at no other edge. Code 11 is ignored.
- R9: When `wake` is high in a tick cycle, `pm_mode` is run after that edge. When `wake` is high in any other cycle, `pm_mode` is run after the next edge. A wake overrides a mode write made in the same cycle.
- R10: When the mode is not powerdown, `clk_out` is high exactly in the tick cycles. It is never high outside a tick cycle.
- R11: `core_en` and `periph_en` are never high outside a tick cycle, and each pulse lasts exactly one input clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | External input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the divisor register, 1 selects the mode request |
| wr_data | input | DIV_W | Write data: divisor value, or the mode code in bits 1:0 |
| wake | input | 1 | Wake request, returns the block to run |
| core_en | output | 1 | Core clock enable |
| periph_en | output | 1 | Peripheral clock enable |
| baud_en | output | 1 | Baud clock enable for the serial units |
| pscl_en | output | 1 | Prescaled clock enable |
| clk_out | output | 1 | Clock output pin level |
| pm_mode | output | 2 | Current power mode code |

## Verification
The bench builds two copies of the block. The first uses the defaults, a 9-bit divisor and BAUD_DIV of 2, which selects the toggle-bit baud variant. The second uses BAUD_DIV of 3, which selects the counter-based baud variant. The full 9-bit divisor lets a directed case run the longest prescaler period of 513 ticks, and random divisors kept small let many terminal counts fall across mode changes and wakes. Random mode writes, including the ignored code 11, and random wake pulses land on both tick and non-tick cycles. This reaches the edge-alignment rules for mode changes and the counter freeze across powerdown.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'b00,
      PM_IDLE = 2'b01,
      PM_DOWN = 2'b10
   } pm_mode_e;

   localparam logic SEL_DIV  = 1'b0;
   localparam logic SEL_MODE = 1'b1;
endpackage

// File: rtl/clkpm_phase.sv
// Divides the input clock by two: tick is high on every second input cycle.
module clkpm_phase (
   input  logic clk_in,
   input  logic rst_n,
   output logic tick
);
   logic ph_q;

   always_ff @(posedge clk_in) begin
      if (!rst_n) ph_q <= 1'b0;
      else        ph_q <= ~ph_q;
   end

   assign tick = ph_q;
endmodule

// File: rtl/clkpm_mode.sv
// Mode request register and boundary-aligned mode state.
module clkpm_mode
   import clkpm_pkg::*;
(
   input  logic     clk_in,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     wr_mode,
   input  logic [1:0] wr_code,
   input  logic     wake,
   output pm_mode_e mode_q,
   output pm_mode_e mode_d
);
   pm_mode_e req_q, req_d;
   logic     code_ok;

   assign code_ok = (wr_code != 2'b11);

   always_comb begin
      if (wake)                   req_d = PM_RUN;
      else if (wr_mode && code_ok) req_d = pm_mode_e'(wr_code);
      else                        req_d = req_q;
   end

   always_comb begin
      if (tick) mode_d = wake ? PM_RUN : req_q;
      else      mode_d = mode_q;
   end

   always_ff @(posedge clk_in) begin
      if (!rst_n) begin
         req_q  <= PM_RUN;
         mode_q <= PM_RUN;
      end else begin
         req_q  <= req_d;
         mode_q <= mode_d;
      end
   end
endmodule

// File: rtl/clkpm_baud.sv
// Baud enable: one pulse per BAUD_DIV peripheral steps.
module clkpm_baud #(
   parameter int BAUD_DIV = 2
) (
   input  logic clk_in,
   input  logic rst_n,
   input  logic step,
   output logic baud_en
);
   if (BAUD_DIV < 2) begin : g_bad
      $error("clkpm_baud: BAUD_DIV must be at least 2");
   end

   if (BAUD_DIV == 2) begin : g_toggle
      logic bt_q;
      always_ff @(posedge clk_in) begin
         if (!rst_n)    bt_q <= 1'b0;
         else if (step) bt_q <= ~bt_q;
      end
      assign baud_en = step & bt_q;
   end else begin : g_count
      localparam int BW = $clog2(BAUD_DIV);
      localparam logic [BW-1:0] LAST = BW'(BAUD_DIV - 1);
      logic [BW-1:0] cnt_q;
      logic          wrap;
      assign wrap = (cnt_q == LAST);
      always_ff @(posedge clk_in) begin
         if (!rst_n)    cnt_q <= '0;
         else if (step) cnt_q <= wrap ? '0 : cnt_q + BW'(1);
      end
      assign baud_en = step & wrap;
   end
endmodule

// File: rtl/clkpm_pscl.sv
// Programmable prescaler: period of (active divisor + 2) steps,
// new divisor loaded at terminal count.
module clkpm_pscl #(
   parameter int DIV_W = 9
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             step,
   input  logic [DIV_W-1:0] div_val,
   output logic             pscl_en
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [DIV_W-1:0] act_q;
   logic             term;

   assign term    = (cnt_q == ({1'b0, act_q} + CNT_W'(1)));
   assign pscl_en = step & term;

   always_ff @(posedge clk_in) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (step) begin
         if (term) begin
            cnt_q <= '0;
            act_q <= div_val;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
   import clkpm_pkg::*;
#(
   parameter int DIV_W    = 9,
   parameter int BAUD_DIV = 2
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [DIV_W-1:0] wr_data,
   input  logic             wake,
   output logic             core_en,
   output logic             periph_en,
   output logic             baud_en,
   output logic             pscl_en,
   output logic             clk_out,
   output logic [1:0]       pm_mode
);
   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_w
      $error("clkpm_ctrl: DIV_W must lie in 2..16");
   end

   logic             tick;
   logic             step;
   pm_mode_e         mode_q, mode_d;
   logic [DIV_W-1:0] div_q;
   logic             clkout_q;

   clkpm_phase u_phase (
      .clk_in (clk_in),
      .rst_n  (rst_n),
      .tick   (tick)
   );

   clkpm_mode u_mode (
      .clk_in  (clk_in),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_mode (wr_en && (wr_addr == SEL_MODE)),
      .wr_code (wr_data[1:0]),
      .wake    (wake),
      .mode_q  (mode_q),
      .mode_d  (mode_d)
   );

   always_ff @(posedge clk_in) begin
      if (!rst_n)                           div_q <= '0;
      else if (wr_en && wr_addr == SEL_DIV) div_q <= wr_data;
   end

   assign step      = tick && (mode_q != PM_DOWN);
   assign core_en   = tick && (mode_q == PM_RUN);
   assign periph_en = step;

   clkpm_baud #(.BAUD_DIV(BAUD_DIV)) u_baud (
      .clk_in  (clk_in),
      .rst_n   (rst_n),
      .step    (step),
      .baud_en (baud_en)
   );

   clkpm_pscl #(.DIV_W(DIV_W)) u_pscl (
      .clk_in  (clk_in),
      .rst_n   (rst_n),
      .step    (step),
      .div_val (div_q),
      .pscl_en (pscl_en)
   );

   // Pin level is registered: high in the next tick cycle unless that cycle
   // falls in powerdown.
   always_ff @(posedge clk_in) begin
      if (!rst_n) clkout_q <= 1'b0;
      else        clkout_q <= ~tick && (mode_d != PM_DOWN);
   end

   assign clk_out = clkout_q;
   assign pm_mode = mode_q;
endmodule

// File: rtl/clkpm_chk.sv
module clkpm_chk (
   input logic       clk_in,
   input logic       rst_n,
   input logic       tick,
   input logic       wake,
   input logic       core_en,
   input logic       periph_en,
   input logic       baud_en,
   input logic       pscl_en,
   input logic       clk_out,
   input logic [1:0] pm_mode
);
   p_single_pulse_r11: assert property (@(posedge clk_in) disable iff (!rst_n)
      periph_en |=> !periph_en);

   p_on_tick_r11: assert property (@(posedge clk_in) disable iff (!rst_n)
      (core_en || periph_en) |-> tick);

   p_core_run_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
      (tick && pm_mode == 2'b00) |-> (core_en && periph_en));

   p_baud_sub_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
      baud_en |-> periph_en);

   p_pscl_sub_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
      pscl_en |-> periph_en);

   p_idle_core_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
      (pm_mode == 2'b01) |-> (!core_en && (periph_en == tick)));

   p_down_quiet_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
      (pm_mode == 2'b10) |-> !(core_en || periph_en || baud_en || pscl_en || clk_out));

   p_mode_edge_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
      !$stable(pm_mode) |-> $past(tick));

   p_mode_code_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
      pm_mode != 2'b11);

   p_wake_run_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
      (wake && tick) |=> (pm_mode == 2'b00));

   p_clkout_tick_r10: assert property (@(posedge clk_in) disable iff (!rst_n)
      clk_out |-> tick);

   p_clkout_live_r10: assert property (@(posedge clk_in) disable iff (!rst_n)
      (tick && pm_mode != 2'b10) |-> clk_out);
endmodule

bind clkpm_ctrl clkpm_chk u_chk (
   .clk_in    (clk_in),
   .rst_n     (rst_n),
   .tick      (tick),
   .wake      (wake),
   .core_en   (core_en),
   .periph_en (periph_en),
   .baud_en   (baud_en),
   .pscl_en   (pscl_en),
   .clk_out   (clk_out),
   .pm_mode   (pm_mode)
);

// File: tb/clkpm_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkpm_ctrl_tb_top;
   localparam int DW = 9;

   logic          clk_in = 1'b0;
   logic          rst_n  = 1'b0;
   logic          wr_en  = 1'b0;
   logic          wr_addr = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wake   = 1'b0;

   logic       core_en, periph_en, baud_en, pscl_en, clk_out;
   logic [1:0] pm_mode;
   logic       core_b, periph_b, baud_b, pscl_b, clkout_b;
   logic [1:0] mode_b;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk_in = ~clk_in;   // 125 MHz

   clkpm_ctrl #(.DIV_W(DW), .BAUD_DIV(2)) dut_i (
      .clk_in(clk_in), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wake(wake), .core_en(core_en), .periph_en(periph_en),
      .baud_en(baud_en), .pscl_en(pscl_en), .clk_out(clk_out), .pm_mode(pm_mode));

   clkpm_ctrl #(.DIV_W(DW), .BAUD_DIV(3)) dut_b3 (
      .clk_in(clk_in), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wake(wake), .core_en(core_b), .periph_en(periph_b),
      .baud_en(baud_b), .pscl_en(pscl_b), .clk_out(clkout_b), .pm_mode(mode_b));

   // ---------------- reference model built from the requirements -------------
   bit m_ph, m_clk;
   int m_mode, m_req, m_div, m_act, m_cnt, m_b2, m_b3;

   always @(posedge clk_in) begin
      if (!rst_n) begin
         m_ph = 0; m_clk = 0; m_mode = 0; m_req = 0;
         m_div = 0; m_act = 0; m_cnt = 0; m_b2 = 0; m_b3 = 0;
      end else begin
         bit tk, pt;
         int nreq;
         tk = m_ph;
         pt = tk && (m_mode != 2);
         if (pt) begin
            if (m_cnt == m_act + 1) begin m_cnt = 0; m_act = m_div; end
            else m_cnt = m_cnt + 1;
            m_b2 = (m_b2 + 1) % 2;
            m_b3 = (m_b3 + 1) % 3;
         end
         if (wake) nreq = 0;
         else if (wr_en && wr_addr && wr_data[1:0] != 2'b11) nreq = int'(wr_data[1:0]);
         else nreq = m_req;
         if (tk) m_mode = wake ? 0 : m_req;
         m_req = nreq;
         if (wr_en && !wr_addr) m_div = int'(wr_data);
         m_ph  = !m_ph;
         m_clk = m_ph && (m_mode != 2);
      end
   end

   function automatic bit exp_periph();
      return m_ph && (m_mode != 2);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int expv);
      n_tests++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
      end
   endtask

   // per-cycle comparison, called at the falling edge
   task automatic check_all();
      bit pe;
      pe = exp_periph();
      chk((m_mode == 1) ? "R6" : "R2", "core_en", int'(core_en), int'(m_ph && m_mode == 0));
      chk((m_mode == 2) ? "R7" : "R2", "periph_en", int'(periph_en), int'(pe));
      chk("R3", "baud_en div2", int'(baud_en), int'(pe && m_b2 == 1));
      chk("R3", "baud_en div3", int'(baud_b), int'(pe && m_b3 == 2));
      chk("R4", "pscl_en", int'(pscl_en), int'(pe && m_cnt == m_act + 1));
      chk("R10", "clk_out", int'(clk_out), int'(m_clk));
      chk("R8", "pm_mode", int'(pm_mode), m_mode);
      chk("R8", "pm_mode copy", int'(mode_b), m_mode);
      chk("R11", "pulse off tick", int'((core_en || periph_en) && !m_ph), 0);
   endtask

   task automatic cyc();
      @(negedge clk_in);
      check_all();
      wr_en = 1'b0; wake = 1'b0;
   endtask

   task automatic write_reg(input bit a, input int v);
      @(negedge clk_in);
      check_all();
      wake = 1'b0;
      wr_en = 1'b1; wr_addr = a; wr_data = DW'(v);
   endtask

   // measure input cycles until next pscl_en pulse
   task automatic gap_to_pulse(output int n);
      n = 0;
      do begin cyc(); n++; end while (!pscl_en && n < 3000);
   endtask

   initial begin
      repeat (200000) @(posedge clk_in);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int g;
      void'($urandom(32'h1F2E3D4C));
      // R1: state during reset
      repeat (3) @(negedge clk_in);
      chk("R1", "core_en", int'(core_en), 0);
      chk("R1", "periph_en", int'(periph_en), 0);
      chk("R1", "baud_en", int'(baud_en), 0);
      chk("R1", "pscl_en", int'(pscl_en), 0);
      chk("R1", "clk_out", int'(clk_out), 0);
      chk("R1", "pm_mode", int'(pm_mode), 0);
      rst_n = 1'b1;
      // R2: first tick right after reset
      cyc();
      chk("R2", "first core pulse", int'(core_en), 1);
      repeat (20) cyc();

      // R5: divisor change mid-period
      write_reg(1'b0, 3);
      gap_to_pulse(g); gap_to_pulse(g); gap_to_pulse(g);
      chk("R4", "gap div 3", g, 10);
      write_reg(1'b0, 6);
      n_tests++;   // the write cycle above counts as the first cycle of the gap
      g = 1;
      do begin cyc(); g++; end while (!pscl_en && g < 3000);
      chk("R5", "gap after change", g, 10);
      gap_to_pulse(g);
      chk("R5", "gap new divisor", g, 16);

      // R4: largest divisor
      write_reg(1'b0, 511);
      gap_to_pulse(g);
      gap_to_pulse(g);
      chk("R4", "gap div 511", g, 1026);

      // R8: reserved code ignored
      write_reg(1'b1, 3);
      repeat (6) cyc();
      chk("R8", "code 11 ignored", int'(pm_mode), 0);

      // R7, R9: powerdown then wake
      write_reg(1'b0, 2);
      write_reg(1'b1, 2);
      repeat (4) cyc();
      chk("R7", "in powerdown", int'(pm_mode), 2);
      repeat (30) begin
         cyc();
         chk("R7", "quiet pins", int'(periph_en | clk_out | pscl_en), 0);
      end
      @(negedge clk_in); check_all(); wake = 1'b1;
      cyc(); cyc();
      chk("R9", "wake to run", int'(pm_mode), 0);

      // R9: wake beats a same-cycle idle write
      @(negedge clk_in); check_all();
      wr_en = 1'b1; wr_addr = 1'b1; wr_data = DW'(1); wake = 1'b1;
      repeat (6) cyc();
      chk("R9", "wake over write", int'(pm_mode), 0);

      // R6: idle keeps peripherals
      write_reg(1'b1, 1);
      repeat (4) cyc();
      chk("R6", "in idle", int'(pm_mode), 1);
      repeat (40) cyc();
      write_reg(1'b1, 0);

      // random phase
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk_in);
         check_all();
         wr_en = ($urandom_range(0, 11) == 0);
         wr_addr = $urandom_range(0, 1);
         if (wr_addr) wr_data = DW'($urandom_range(0, 511));
         else if ($urandom_range(0, 7) == 0) wr_data = DW'($urandom_range(0, 511));
         else wr_data = DW'($urandom_range(0, 12));
         wake = ($urandom_range(0, 29) == 0);
      end
      repeat (4) cyc();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule